// File: doc/BRIEF.md
# Serial-Configured Ten-Way Clock Gate

This block is a write-only two-wire serial slave that sets which of ten copies of a buffered clock are allowed to toggle. A fast system clock oversamples the serial clock and data lines. The slave finds start and stop conditions and checks the address byte against one fixed device address. It then acknowledges two header bytes that carry no meaning. After those it loads up to three mask bytes, always starting with the first mask byte and going on in sequence. There is no read path and no subaddress. To reach a later mask byte, the host must resend every earlier one in the same transfer.

Each clock output either follows the buffered clock input without inversion or is held low. This depends on its enable bit. A separate active-low pin clears the output-enable vector, which a pad ring uses to put every clock output into high impedance. This pin acts regardless of the mask contents.

Top module: `clk_fanout_cfg`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Outside a start-to-stop window no byte is acknowledged and the mask does not change.
- R2: The address byte 0xD2 is acknowledged. That byte is the 7-bit address 1101001 followed by the write bit 0, sent MSB first. An acknowledge means `sda_pull_o` is 1 from the SCL fall after the eighth bit until the SCL fall that ends the ninth pulse. `sda_pull_o` is 0 while SCL is high during every data bit.
- R3: The slave does not acknowledge a non-matching address or a read request (0xD3). It then acknowledges nothing and changes no mask bit until the next start.
- R4: The two bytes that follow an accepted address are acknowledged, and their values have no effect on the mask.
- R5: The data bytes, sent MSB first, load mask byte 0, then 1, then 2, in that order. Outputs 0–3 take bits 3:0 of mask byte 0. Outputs 4–7 take bits 7:4 of mask byte 1. Output 8 takes bit 6 of mask byte 2, and output 9 takes bit 7 of mask byte 2. A 1 enables an output.
- R6: Data bytes after the third are acknowledged and change nothing.
- R7: After reset every output is enabled and `sda_pull_o` is 0.
- R8: An enabled output equals `clk_src_i`. A disabled output is 0.
- R9: Every bit of `clk_oe_o` equals `out_en_i`, so a low pin sets all ten output enables to 0 whatever the mask holds.
- R10: Each mask byte takes effect when its own byte completes, before its acknowledge ends. A transfer that is cut short keeps the bytes already received.
- R11: A repeated start in the middle of a transfer restarts framing, so the next byte is taken as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| clk_src_i | input | 1 | Buffered clock to be fanned out |
| out_en_i | input | 1 | Active-high drive enable; low places all outputs in high impedance |
| clk_o | output | 10 | Gated clock copies |
| clk_oe_o | output | 10 | Per-output drive enable for the pad ring |

## Verification
A table of transfers is replayed. It covers full writes, partial writes, writes that clear and then restore the mask, and rejected addresses (a read bit, and an address one bit away). Each entry tells the acknowledge decision apart from the mask decode. Directed transfers append bytes past the third, cut a transfer short with a repeated start, and clock bytes after a stop with no new start. These separate commit-per-byte behaviour from commit-on-stop behaviour. Every mask is read back at the clock outputs with the source clock both high and low. This shows that a gated output is held low and not merely inverted.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_BITS    = 2'd1,
    RX_ACKWAIT = 2'd2,
    RX_ACK     = 2'd3
  } rx_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_rx_frame.sv
module cfg_rx_frame
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         HDR_BYTES = 2,
  parameter int         NUM_REG   = 3,
  localparam int        IDX_W     = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl,
  input  logic             sda,
  output logic             sda_pull,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam int              CNT_W     = $clog2(HDR_BYTES + NUM_REG + 2);
  localparam logic [CNT_W-1:0] FIRST_REG = CNT_W'(HDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(HDR_BYTES + NUM_REG + 1);
  localparam logic [7:0]       ADDR_W    = {DEV_ADDR, 1'b0};

  rx_state_t        state;
  logic             scl_q, sda_q;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [6:0]       shreg;

  logic             start_c, stop_c, rise_c, fall_c, in_regs;
  logic [7:0]       full_byte;
  logic [CNT_W-1:0] reg_off;

  always_comb begin
    start_c   = scl & scl_q & sda_q & ~sda;
    stop_c    = scl & scl_q & ~sda_q & sda;
    rise_c    = scl & ~scl_q;
    fall_c    = ~scl & scl_q;
    full_byte = {shreg, sda};
    in_regs   = (byte_cnt >= FIRST_REG) && (byte_cnt < LAST_IDX);
    reg_off   = byte_cnt - FIRST_REG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      wr_stb <= 1'b0;
      if (start_c) begin
        state    <= RX_BITS;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        state    <= RX_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          RX_BITS: begin
            if (rise_c) begin
              shreg   <= {shreg[5:0], sda};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (byte_cnt == '0 && full_byte != ADDR_W) begin
                  state <= RX_IDLE;
                end else begin
                  state <= RX_ACKWAIT;
                  if (in_regs) begin
                    wr_stb  <= 1'b1;
                    wr_idx  <= reg_off[IDX_W-1:0];
                    wr_data <= full_byte;
                  end
                end
              end
            end
          end
          RX_ACKWAIT: begin
            if (fall_c) begin
              sda_pull <= 1'b1;
              state    <= RX_ACK;
            end
          end
          RX_ACK: begin
            if (fall_c) begin
              sda_pull <= 1'b0;
              state    <= RX_BITS;
              bit_cnt  <= '0;
              if (byte_cnt != LAST_IDX) byte_cnt <= byte_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_gate_map.sv
module cfg_gate_map #(
  parameter int  NUM_OUT = 10,
  parameter int  NUM_REG = 3,
  localparam int IDX_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  output logic [NUM_OUT-1:0] en_o
);
  // Outputs 0..7 sit on their own bit number in bytes 0 and 1 (four per
  // byte); outputs past 7 use the top bits of byte 2, lowest at bit 6.
  function automatic int out_reg(input int i);
    return (i < 8) ? (i / 4) : 2;
  endfunction

  function automatic int out_bit(input int i);
    return (i < 8) ? i : (i - 2);
  endfunction

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam int RI = out_reg(i);
    localparam int BI = out_bit(i);
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b1;
      else if (wr_stb && wr_idx == IDX_W'(RI)) en_q <= wr_data[BI];
    end
    assign en_o[i] = en_q;
  end
endmodule

// File: rtl/clk_fanout_cfg.sv
module clk_fanout_cfg #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         HDR_BYTES   = 2,
  parameter int         NUM_REG     = 3,
  parameter int         NUM_OUT     = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               clk_src_i,
  input  logic               out_en_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  localparam int IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;

  logic [1:0]         line_s;
  logic               wr_stb;
  logic [IDX_W-1:0]   wr_idx;
  logic [7:0]         wr_data;
  logic [NUM_OUT-1:0] en;

  cfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (line_s)
  );

  cfg_rx_frame #(.DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES), .NUM_REG(NUM_REG)) i_rx (
    .clk      (clk),
    .rst      (rst),
    .scl      (line_s[1]),
    .sda      (line_s[0]),
    .sda_pull (sda_pull_o),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  cfg_gate_map #(.NUM_OUT(NUM_OUT), .NUM_REG(NUM_REG)) i_map (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .en_o    (en)
  );

  assign clk_o    = {NUM_OUT{clk_src_i}} & en;
  assign clk_oe_o = {NUM_OUT{out_en_i}};
endmodule

// File: rtl/clk_fanout_cfg_chk.sv
module clk_fanout_cfg_chk #(
  parameter int NUM_OUT = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_i,
  input logic               sda_pull_o,
  input logic               clk_src_i,
  input logic               out_en_i,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] clk_oe_o
);
  // R2: the pull only moves while the serial clock is low
  a_r2_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_i);

  // R2: once asserted the acknowledge lasts more than one sample
  a_r2_pull_min_len: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |=> sda_pull_o);

  // R7: leaving reset the line is released
  a_r7_reset_release: assert property (@(posedge clk)
    rst |=> !sda_pull_o);

  // R8: no output is high while the source is low
  a_r8_src_low: assert property (@(posedge clk) disable iff (rst)
    !clk_src_i |-> (clk_o == '0));

  // R9: all drive enables share one state
  a_r9_oe_uniform: assert property (@(posedge clk) disable iff (rst)
    (clk_oe_o == '0) || (clk_oe_o == '1));

  // R9: a low pin turns every driver off
  a_r9_oe_off: assert property (@(posedge clk) disable iff (rst)
    !out_en_i |-> (clk_oe_o == '0));
endmodule

bind clk_fanout_cfg clk_fanout_cfg_chk #(.NUM_OUT(NUM_OUT)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .clk_src_i  (clk_src_i),
  .out_en_i   (out_en_i),
  .clk_o      (clk_o),
  .clk_oe_o   (clk_oe_o)
);

// File: tb/test_clk_fanout_cfg.sv
module test_clk_fanout_cfg;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NOUT       = 10;
  localparam int WDOG       = 150000;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] hdr;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [7:0] d2;
    logic [1:0] nd;
    logic       ack;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{8'hD2, 8'hA5, 8'h00, 8'h00, 8'h00, 2'd3, 1'b1},
    '{8'hD2, 8'hFF, 8'h0F, 8'hF0, 8'hC0, 2'd3, 1'b1},
    '{8'hD2, 8'h00, 8'h05, 8'h00, 8'h00, 2'd1, 1'b1},
    '{8'hD3, 8'h00, 8'h00, 8'h00, 8'h00, 2'd3, 1'b0},
    '{8'hD6, 8'h00, 8'h00, 8'h00, 8'h00, 2'd3, 1'b0},
    '{8'hD2, 8'h3C, 8'h3C, 8'hA0, 8'h40, 2'd3, 1'b1},
    '{8'hD2, 8'h81, 8'hFF, 8'h00, 8'h00, 2'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic clk_src = 1'b0;
  logic out_en = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [NOUT-1:0] clk_out, clk_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [NOUT-1:0] mdl;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_fanout_cfg i_clk_fanout_cfg (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .clk_src_i  (clk_src),
    .out_en_i   (out_en),
    .clk_o      (clk_out),
    .clk_oe_o   (clk_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NOUT-1:0] apply(input logic [NOUT-1:0] m, input int idx,
                                            input logic [7:0] v);
    logic [NOUT-1:0] r = m;
    case (idx)
      0: r[3:0] = v[3:0];
      1: r[7:4] = v[7:4];
      2: begin r[8] = v[6]; r[9] = v[7]; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic bad = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq();
      if (sda_pull) bad = 1'b1;
      wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = sda_pull;
    wq(); scl_m = 1'b0; wq();
    chk("R2 pull during data bits", {31'd0, bad}, 32'd0);
  endtask

  task automatic check_mask(input string req, input logic [NOUT-1:0] exp);
    clk_src = 1'b1; #1;
    chk(req, {22'd0, clk_out}, {22'd0, exp});
    clk_src = 1'b0; #1;
    chk("R8 source low gives all low", {22'd0, clk_out}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] db;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7 reset state
    chk("R7 pull after reset", {31'd0, sda_pull}, 32'd0);
    mdl = '1;
    check_mask("R7 all enabled after reset", mdl);
    chk("R9 drivers on with pin high", {22'd0, clk_oe}, {22'd0, {NOUT{1'b1}}});

    // table of transfers (R2 R3 R4 R5 R8 R10)
    for (int v = 0; v < NVEC; v++) begin
      do_start();
      send_byte(VEC[v].addr, a);
      chk(VEC[v].ack ? "R2 address ack" : "R3 address rejected", {31'd0, a}, {31'd0, VEC[v].ack});
      for (int h = 0; h < 2; h++) begin
        send_byte(VEC[v].hdr, a);
        chk(VEC[v].ack ? "R4 header ack" : "R3 no ack after reject", {31'd0, a}, {31'd0, VEC[v].ack});
      end
      for (int d = 0; d < int'(VEC[v].nd); d++) begin
        db = (d == 0) ? VEC[v].d0 : (d == 1) ? VEC[v].d1 : VEC[v].d2;
        send_byte(db, a);
        chk(VEC[v].ack ? "R5 data ack" : "R3 data ignored", {31'd0, a}, {31'd0, VEC[v].ack});
        if (VEC[v].ack) mdl = apply(mdl, d, db);
      end
      do_stop();
      check_mask(VEC[v].ack ? "R5 R10 mask after write" : "R3 mask unchanged", mdl);
    end

    // R6 bytes past the third
    do_start();
    send_byte(8'hD2, a); chk("R6 address", {31'd0, a}, 32'd1);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h33, a); mdl = apply(mdl, 0, 8'h33);
    send_byte(8'h50, a); mdl = apply(mdl, 1, 8'h50);
    send_byte(8'h80, a); mdl = apply(mdl, 2, 8'h80);
    send_byte(8'h00, a); chk("R6 extra byte ack", {31'd0, a}, 32'd1);
    send_byte(8'h00, a); chk("R6 extra byte ack", {31'd0, a}, 32'd1);
    do_stop();
    check_mask("R6 extra bytes discarded", mdl);

    // R10 commit per byte, R11 repeated start
    do_start();
    send_byte(8'hD2, a); send_byte(8'h11, a); send_byte(8'h22, a);
    send_byte(8'h0A, a); mdl = apply(mdl, 0, 8'h0A);
    check_mask("R10 byte committed before stop", mdl);
    do_start();
    send_byte(8'hD2, a); chk("R11 address after repeated start", {31'd0, a}, 32'd1);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h06, a); mdl = apply(mdl, 0, 8'h06);
    send_byte(8'h90, a); mdl = apply(mdl, 1, 8'h90);
    do_stop();
    check_mask("R11 framing restarted", mdl);

    // R1 bytes with no start
    send_byte(8'hD2, a); chk("R1 no ack without start", {31'd0, a}, 32'd0);
    send_byte(8'h00, a); chk("R1 no ack without start", {31'd0, a}, 32'd0);
    do_stop();
    check_mask("R1 mask unchanged without start", mdl);
    do_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    do_stop();
    send_byte(8'h00, a); chk("R1 no ack after stop", {31'd0, a}, 32'd0);
    do_stop();
    check_mask("R1 stop ends transfer", mdl);

    // R9 drive enable pin
    out_en = 1'b0; #1;
    chk("R9 drivers off with pin low", {22'd0, clk_oe}, 32'd0);
    out_en = 1'b1; #1;
    chk("R9 drivers on with pin high", {22'd0, clk_oe}, {22'd0, {NOUT{1'b1}}});

    // R7 reset in mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    mdl = '1;
    check_mask("R7 reset restores enables", mdl);
    chk("R7 pull after reset", {31'd0, sda_pull}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule